// File: doc/BRIEF.md
# Dual-Processor IPC Mailbox

This block lets a requesting processor (the host) and a responding I/O processor pass command pointers to each other. Each processor has its own simple synchronous register port. The host writes the physical address of a command structure into the request pointer and then rings a doorbell in the shared flag register. That raises an interrupt to the I/O processor. The I/O processor finishes the work, copies the pointer into the reply pointer and rings its own doorbells. The reply pattern is 0x14, which sets flag bits 2 and 4, and it raises an interrupt back to the host. The command structures themselves live in external memory. Only the two pointers and the flags are held here.

Each flag bit belongs to one side. The owner sets a bit by writing 1 to it, and the receiver clears it by writing 1 to it. Writing 0 does nothing. When both ports write the flag register in the same cycle, the set and clear requests are merged bit by bit, and a set beats a clear. The register window repeats every 0x400 bytes.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, the pointers, the flags, both read-data outputs and both interrupts are zero.
- R2: A host write to word offset 0x0 stores the request pointer, and both ports read it back at 0x0. An I/O-processor write to 0x0 is ignored.
- R3: An I/O-processor write to offset 0x8 stores the reply pointer, and both ports read it back at 0x8. A host write to 0x8 is ignored.
- R4: The flag register sits at offset 0x4, is 8 bits wide and reads zero-extended. Host-owned bits are 0, 1 and 3. A host write sets each host-owned bit where the written data holds a 1. A host write of 1 to a clear I/O-owned bit does not set it.
- R5: I/O-owned flag bits are 2, 4, 5, 6 and 7. An I/O-processor write of 0x14 sets bits 2 and 4, and irq_host is high in the cycle after the write.
- R6: irq_iop is high exactly while any host-owned bit is set. irq_host is high exactly while any I/O-owned bit is set. Neither interrupt changes in a cycle with no write.
- R7: Writing 1 to a bit owned by the other side clears it. Writing 0 to any flag bit leaves it unchanged.
- R8: When both ports write the flag register in the same cycle, all set and clear requests from both ports take effect. Where one bit is both set and cleared, it ends up set.
- R9: Address bits 10 and above, and bits 1:0, are ignored, so the window mirrors every 0x400 bytes. Word offsets other than 0x0, 0x4 and 0x8 read zero, and writes to them are ignored.
- R10: The read data of a port changes only on the clock edge where that port's read strobe is high. At that edge it takes the value the register held before the edge. At all other times it holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | ADDR_W | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, registered |
| i_wr | input | 1 | I/O-processor write strobe |
| i_rd | input | 1 | I/O-processor read strobe |
| i_addr | input | ADDR_W | I/O-processor byte address |
| i_wdata | input | 32 | I/O-processor write data |
| i_rdata | output | 32 | I/O-processor read data, registered |
| irq_host | output | 1 | Interrupt to the host: an I/O-owned flag is set |
| irq_iop | output | 1 | Interrupt to the I/O processor: a host-owned flag is set |

## Verification
The bench uses the default parameters: a 16-bit address, an 8-bit flag register, and the masks 0x0B for the host and 0xF4 for the I/O processor. The 16-bit address leaves six bits above the window, so the bench can reach mirrored addresses such as 0x0400, 0x4404 and 0x8008. With the two ownership masks the bench can collide a set against a clear on the same bit, in the same cycle, from opposite ports.

// File: rtl/ipc_mbx_pkg.sv
package ipc_mbx_pkg;

    localparam int DATA_W  = 32;
    localparam int WIN_LSB = 2;
    localparam int WIN_MSB = 9;
    localparam int WORD_W  = WIN_MSB - WIN_LSB + 1;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_REQ,
        SEL_FLAG,
        SEL_RPLY
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        reg_sel_e          sel;
        logic [DATA_W-1:0] wdata;
    } bus_op_t;

    function automatic reg_sel_e decode_word(input logic [WORD_W-1:0] w);
        case (w)
            WORD_W'(0): return SEL_REQ;
            WORD_W'(1): return SEL_FLAG;
            WORD_W'(2): return SEL_RPLY;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/ipc_mbx_port_dec.sv
module ipc_mbx_port_dec
    import ipc_mbx_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output bus_op_t           op
);
    // bits outside the window index are deliberately dropped (mirroring)
    logic unused_addr_bits;
    assign unused_addr_bits = ^{addr[ADDR_W-1:WIN_MSB+1], addr[WIN_LSB-1:0]};

    always_comb begin
        op.wr    = wr;
        op.rd    = rd;
        op.sel   = decode_word(addr[WIN_MSB:WIN_LSB]);
        op.wdata = wdata;
    end
endmodule

// File: rtl/ipc_mbx_ptr.sv
module ipc_mbx_ptr
    import ipc_mbx_pkg::*;
#(
    parameter reg_sel_e MATCH = SEL_REQ
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_op_t           op,
    output logic [DATA_W-1:0] q
);
    logic unused_rd;
    assign unused_rd = op.rd;

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (op.wr && op.sel == MATCH)
            q <= op.wdata;
    end
endmodule

// File: rtl/ipc_mbx_flags.sv
module ipc_mbx_flags
    import ipc_mbx_pkg::*;
#(
    parameter int                FLAG_W    = 8,
    parameter logic [FLAG_W-1:0] HOST_MASK = 8'h0B,
    parameter logic [FLAG_W-1:0] IOP_MASK  = 8'hF4
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_op_t           h_op,
    input  bus_op_t           i_op,
    output logic [FLAG_W-1:0] flags,
    output logic              irq_host,
    output logic              irq_iop
);
    logic [FLAG_W-1:0] h_bits, i_bits, set_v, clr_v, nxt;

    logic unused_flag_in;
    assign unused_flag_in = ^{h_op.rd, i_op.rd,
                              h_op.wdata[DATA_W-1:FLAG_W], i_op.wdata[DATA_W-1:FLAG_W]};

    always_comb begin
        h_bits = (h_op.wr && h_op.sel == SEL_FLAG) ? h_op.wdata[FLAG_W-1:0] : '0;
        i_bits = (i_op.wr && i_op.sel == SEL_FLAG) ? i_op.wdata[FLAG_W-1:0] : '0;
        // owners set, receivers clear; set wins on a shared bit
        set_v  = (h_bits & HOST_MASK) | (i_bits & IOP_MASK);
        clr_v  = (h_bits & IOP_MASK)  | (i_bits & HOST_MASK);
        nxt    = (flags & ~clr_v) | set_v;
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= nxt;
    end

    assign irq_iop  = |(flags & HOST_MASK);
    assign irq_host = |(flags & IOP_MASK);
endmodule

// File: rtl/ipc_mbx_rdport.sv
module ipc_mbx_rdport
    import ipc_mbx_pkg::*;
#(
    parameter int FLAG_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_op_t           op,
    input  logic [DATA_W-1:0] req_ptr,
    input  logic [FLAG_W-1:0] flags,
    input  logic [DATA_W-1:0] rply_ptr,
    output logic [DATA_W-1:0] rdata
);
    localparam int PAD_W = DATA_W - FLAG_W;

    logic unused_wr;
    assign unused_wr = ^{op.wr, op.wdata};

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (op.rd) begin
            case (op.sel)
                SEL_REQ:  rdata <= req_ptr;
                SEL_FLAG: rdata <= {{PAD_W{1'b0}}, flags};
                SEL_RPLY: rdata <= rply_ptr;
                default:  rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import ipc_mbx_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                FLAG_W    = 8,
    parameter logic [FLAG_W-1:0] HOST_MASK = 8'h0B,
    parameter logic [FLAG_W-1:0] IOP_MASK  = 8'hF4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              h_wr,
    input  logic              h_rd,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [31:0]       h_wdata,
    output logic [31:0]       h_rdata,
    input  logic              i_wr,
    input  logic              i_rd,
    input  logic [ADDR_W-1:0] i_addr,
    input  logic [31:0]       i_wdata,
    output logic [31:0]       i_rdata,
    output logic              irq_host,
    output logic              irq_iop
);
    localparam int NPORT = 2;
    localparam int P_HOST = 0;
    localparam int P_IOP  = 1;

    logic              wr_a    [NPORT];
    logic              rd_a    [NPORT];
    logic [ADDR_W-1:0] addr_a  [NPORT];
    logic [DATA_W-1:0] wdata_a [NPORT];
    logic [DATA_W-1:0] rdata_a [NPORT];
    bus_op_t           op_a    [NPORT];

    logic [DATA_W-1:0] req_ptr, rply_ptr;
    logic [FLAG_W-1:0] flags;

    assign wr_a[P_HOST]    = h_wr;
    assign rd_a[P_HOST]    = h_rd;
    assign addr_a[P_HOST]  = h_addr;
    assign wdata_a[P_HOST] = h_wdata;
    assign wr_a[P_IOP]     = i_wr;
    assign rd_a[P_IOP]     = i_rd;
    assign addr_a[P_IOP]   = i_addr;
    assign wdata_a[P_IOP]  = i_wdata;
    assign h_rdata         = rdata_a[P_HOST];
    assign i_rdata         = rdata_a[P_IOP];

    for (genvar s = 0; s < NPORT; s++) begin : g_port
        ipc_mbx_port_dec #(.ADDR_W(ADDR_W)) u_dec (
            .wr(wr_a[s]), .rd(rd_a[s]), .addr(addr_a[s]),
            .wdata(wdata_a[s]), .op(op_a[s])
        );
        ipc_mbx_rdport #(.FLAG_W(FLAG_W)) u_rd (
            .clk(clk), .rst(rst), .op(op_a[s]),
            .req_ptr(req_ptr), .flags(flags), .rply_ptr(rply_ptr),
            .rdata(rdata_a[s])
        );
    end

    // request pointer is owned by the host port only
    ipc_mbx_ptr #(.MATCH(SEL_REQ)) u_req (
        .clk(clk), .rst(rst), .op(op_a[P_HOST]), .q(req_ptr)
    );

    // reply pointer is owned by the I/O-processor port only
    ipc_mbx_ptr #(.MATCH(SEL_RPLY)) u_rply (
        .clk(clk), .rst(rst), .op(op_a[P_IOP]), .q(rply_ptr)
    );

    ipc_mbx_flags #(
        .FLAG_W(FLAG_W), .HOST_MASK(HOST_MASK), .IOP_MASK(IOP_MASK)
    ) u_flags (
        .clk(clk), .rst(rst), .h_op(op_a[P_HOST]), .i_op(op_a[P_IOP]),
        .flags(flags), .irq_host(irq_host), .irq_iop(irq_iop)
    );
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
    parameter int                ADDR_W    = 16,
    parameter int                FLAG_W    = 8,
    parameter logic [FLAG_W-1:0] HOST_MASK = 8'h0B,
    parameter logic [FLAG_W-1:0] IOP_MASK  = 8'hF4
) (
    input logic              clk,
    input logic              rst,
    input logic              h_wr,
    input logic              h_rd,
    input logic [ADDR_W-1:0] h_addr,
    input logic [31:0]       h_wdata,
    input logic [31:0]       h_rdata,
    input logic              i_wr,
    input logic              i_rd,
    input logic [ADDR_W-1:0] i_addr,
    input logic [31:0]       i_wdata,
    input logic [31:0]       i_rdata,
    input logic              irq_host,
    input logic              irq_iop
);
    logic h_flag_wr, i_flag_wr;
    assign h_flag_wr = h_wr && h_addr[9:2] == 8'd1;
    assign i_flag_wr = i_wr && i_addr[9:2] == 8'd1;

    // R1
    reset_clean_chk: assert property (@(posedge clk)
        rst |=> (h_rdata == 32'd0 && i_rdata == 32'd0 && !irq_host && !irq_iop));

    // R5
    reply_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (i_flag_wr && (i_wdata[FLAG_W-1:0] & IOP_MASK) != '0) |=> irq_host);

    // R8
    host_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (h_flag_wr && (h_wdata[FLAG_W-1:0] & HOST_MASK) != '0) |=> irq_iop);

    // R7
    iop_clear_all_chk: assert property (@(posedge clk) disable iff (rst)
        (i_flag_wr && (i_wdata[FLAG_W-1:0] & HOST_MASK) == HOST_MASK && !h_flag_wr)
        |=> !irq_iop);

    // R6
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(h_wr || i_wr) |=> ($stable(irq_host) && $stable(irq_iop)));

    // R10
    h_rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !h_rd |=> $stable(h_rdata));

    // R10
    i_rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !i_rd |=> $stable(i_rdata));
endmodule

bind ipc_mailbox ipc_mailbox_chk #(
    .ADDR_W(ADDR_W), .FLAG_W(FLAG_W), .HOST_MASK(HOST_MASK), .IOP_MASK(IOP_MASK)
) u_chk (.*);

// File: tb/tb_ipc_mailbox.sv
module tb_ipc_mailbox;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              h_wr = 1'b0, h_rd = 1'b0, i_wr = 1'b0, i_rd = 1'b0;
    logic [ADDR_W-1:0] h_addr = '0, i_addr = '0;
    logic [31:0]       h_wdata = '0, i_wdata = '0;
    logic [31:0]       h_rdata, i_rdata;
    logic              irq_host, irq_iop;

    int n_vec = 0;
    int n_err = 0;
    bit done  = 1'b0;

    ipc_mailbox #(.ADDR_W(ADDR_W)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        h_wr = 0; h_rd = 0; i_wr = 0; i_rd = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr_host(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        h_wr = 1; h_addr = a; h_wdata = d;
        @(negedge clk);
        h_wr = 0;
    endtask

    task automatic wr_iop(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        i_wr = 1; i_addr = a; i_wdata = d;
        @(negedge clk);
        i_wr = 0;
    endtask

    task automatic wr_both(input logic [31:0] hd, input logic [31:0] id);
        @(negedge clk);
        h_wr = 1; h_addr = 16'h0004; h_wdata = hd;
        i_wr = 1; i_addr = 16'h0004; i_wdata = id;
        @(negedge clk);
        h_wr = 0; i_wr = 0;
    endtask

    task automatic rd_host(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        h_rd = 1; h_addr = a;
        @(negedge clk);
        h_rd = 0;
        d = h_rdata;
    endtask

    task automatic rd_iop(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        i_rd = 1; i_addr = a;
        @(negedge clk);
        i_rd = 0;
        d = i_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        chk("R1 h_rdata", h_rdata, 0);
        chk("R1 i_rdata", i_rdata, 0);
        chk("R1 irq_host", {31'd0, irq_host}, 0);
        chk("R1 irq_iop", {31'd0, irq_iop}, 0);
        rd_host(16'h0000, d); chk("R1 req ptr", d, 0);
        rd_iop(16'h0004, d);  chk("R1 flags", d, 0);
        rd_host(16'h0008, d); chk("R1 reply ptr", d, 0);
    endtask

    task automatic t_request();
        logic [31:0] d;
        do_reset();
        wr_host(16'h0000, 32'h0012_3440);
        rd_host(16'h0000, d); chk("R2 host reads req", d, 32'h0012_3440);
        rd_iop(16'h0000, d);  chk("R2 iop reads req", d, 32'h0012_3440);
        wr_iop(16'h0000, 32'hDEAD_BEEF);
        rd_host(16'h0000, d); chk("R2 iop write ignored", d, 32'h0012_3440);
        wr_host(16'h0004, 32'h0000_0001);
        chk("R4 bit0 raises irq_iop", {31'd0, irq_iop}, 1);
        chk("R6 irq_host stays low", {31'd0, irq_host}, 0);
        rd_iop(16'h0004, d);  chk("R4 flags after bit0", d, 32'h1);
    endtask

    task automatic t_ownership();
        logic [31:0] d;
        do_reset();
        wr_host(16'h0004, 32'hFFFF_FFFF);
        rd_host(16'h0004, d); chk("R4 host sets only own bits", d, 32'h0B);
        chk("R6 irq_host low with host bits", {31'd0, irq_host}, 0);
        wr_iop(16'h0004, 32'h0000_0008);
        rd_host(16'h0004, d); chk("R7 iop clears bit3", d, 32'h03);
        wr_iop(16'h0004, 32'h0000_0000);
        rd_host(16'h0004, d); chk("R7 zero write no effect", d, 32'h03);
        wr_iop(16'h0004, 32'h0000_0003);
        chk("R6 irq_iop low after clear", {31'd0, irq_iop}, 0);
    endtask

    task automatic t_reply();
        logic [31:0] d;
        do_reset();
        wr_host(16'h0000, 32'h0012_3440);
        wr_host(16'h0004, 32'h1);
        wr_iop(16'h0008, 32'h0012_3440);
        rd_host(16'h0008, d); chk("R3 host reads reply", d, 32'h0012_3440);
        wr_host(16'h0008, 32'h0000_FFFF);
        rd_iop(16'h0008, d);  chk("R3 host write ignored", d, 32'h0012_3440);
        wr_iop(16'h0004, 32'h1);
        chk("R7 iop acks request", {31'd0, irq_iop}, 0);
        wr_iop(16'h0004, 32'h14);
        chk("R5 reply raises irq_host", {31'd0, irq_host}, 1);
        rd_host(16'h0004, d); chk("R5 flags 0x14", d, 32'h14);
        wr_host(16'h0004, 32'h04);
        rd_host(16'h0004, d); chk("R7 host clears bit2", d, 32'h10);
        chk("R6 irq_host held by bit4", {31'd0, irq_host}, 1);
        wr_host(16'h0004, 32'h10);
        chk("R6 irq_host drops", {31'd0, irq_host}, 0);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        do_reset();
        wr_both(32'h01, 32'h01);
        rd_host(16'h0004, d); chk("R8 host set beats iop clear", d, 32'h01);
        wr_both(32'h02, 32'h10);
        rd_iop(16'h0004, d);  chk("R8 both sets land", d, 32'h13);
        wr_both(32'h10, 32'h10);
        rd_host(16'h0004, d); chk("R8 iop set beats host clear", d, 32'h13);
        wr_both(32'h10, 32'h03);
        rd_host(16'h0004, d); chk("R8 both clears land", d, 32'h00);
    endtask

    task automatic t_mirror();
        logic [31:0] d;
        do_reset();
        wr_host(16'h0400, 32'hA5A5_0000);
        rd_iop(16'h8000, d);  chk("R9 mirrored req", d, 32'hA5A5_0000);
        rd_host(16'h0002, d); chk("R9 low bits ignored", d, 32'hA5A5_0000);
        wr_host(16'h4404, 32'h02);
        rd_host(16'h0004, d); chk("R9 mirrored flag", d, 32'h02);
        wr_iop(16'h8008, 32'h0000_7770);
        rd_host(16'hFC08, d); chk("R9 mirrored reply", d, 32'h0000_7770);
        wr_host(16'h000C, 32'hFFFF_FFFF);
        rd_host(16'h000C, d); chk("R9 unmapped reads zero", d, 0);
        rd_host(16'h0000, d); chk("R9 unmapped write ignored", d, 32'hA5A5_0000);
    endtask

    task automatic t_rdhold();
        logic [31:0] d;
        do_reset();
        wr_host(16'h0000, 32'h1111_2222);
        rd_host(16'h0000, d);
        wr_host(16'h0000, 32'h3333_4444);
        @(negedge clk);
        chk("R10 rdata holds without strobe", h_rdata, 32'h1111_2222);
        @(negedge clk);
        h_rd = 1; h_addr = 16'h0000;
        h_wr = 1; h_wdata = 32'h5555_6666;
        @(negedge clk);
        h_rd = 0; h_wr = 0;
        chk("R10 read sees pre-edge value", h_rdata, 32'h3333_4444);
    endtask

    initial begin
        t_reset();
        t_request();
        t_ownership();
        t_reply();
        t_collide();
        t_mirror();
        t_rdhold();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end
endmodule